// File: doc/BRIEF.md
# FIR Receive Byte Framer with Delimiter Escaping

This block sits between the 4 Mb/s receive demodulator and the receive byte buffer. The demodulator delivers a byte stream in which each beat is one of three things: a frame-open marker, a frame-close marker or a data byte. The framer turns that stream into the byte sequence written into the buffer. Every frame is bracketed by a pair of 0x7E delimiter bytes at each end, and any data byte that could be mistaken for a delimiter is replaced by a two-byte escape. After this step 0x7E never appears inside a frame body, so host software can split the buffered bytes at delimiters without any other context.

The framer does not check frames. The 32-bit check sequence at the end of each frame reaches the framer as ordinary data and is escaped in the same way. Frames are written back to back, and the host may read any prefix of the buffer. The framer also keeps a sticky overflow flag. It is set when the demodulator reports that a byte arrived while the framer could not accept one, and it is cleared when the next frame opens.

Top module: `fir_rx_framer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: An open beat (`in_valid` with `in_sof`=1) accepted while no frame is open produces exactly two 0x7E bytes and opens a frame. `in_sof` takes priority over `in_eof`.
- R3: A data beat (`in_sof`=0, `in_eof`=0) accepted inside a frame whose byte is not 0x7D, 0x7E or 0x7F is output once and unchanged.
- R4: A data byte of 0x7D, 0x7E or 0x7F inside a frame is output as 0x7D followed by the byte XOR 0x20, giving 0x5D, 0x5E or 0x5F. An output 0x7D is always followed directly by one of those three codes.
- R5: A close beat (`in_eof`=1, `in_sof`=0) accepted inside a frame produces exactly two 0x7E bytes and closes the frame.
- R6: A close beat accepted while no frame is open is consumed and produces no output.
- R7: A data beat accepted while no frame is open is consumed and produces no output.
- R8: An open beat accepted while a frame is open produces four 0x7E bytes: two close the old frame and two open the new one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next cycle.
- R10: `in_ready` is 1 exactly when no output byte is pending, or when the single pending byte is being taken in that cycle. Plain data therefore flows at one byte per cycle, and each multi-byte expansion holds `in_ready` low for one cycle per extra byte when `out_ready` stays high. Whenever `in_ready` is 0, `out_valid` is 1.
- R11: An `in_overrun` pulse sets `overflow` on the next cycle. `overflow` stays set until an open beat is accepted without `in_overrun` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Demodulator beat valid |
| in_ready | output | 1 | Framer can take a beat this cycle |
| in_data | input | 8 | Received byte (ignored on marker beats) |
| in_sof | input | 1 | Beat is a frame-open marker |
| in_eof | input | 1 | Beat is a frame-close marker |
| in_overrun | input | 1 | Demodulator lost a byte to backpressure |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Buffer accepts the output byte |
| out_data | output | 8 | Byte written to the receive buffer |
| overflow | output | 1 | Sticky overrun indication |

## Verification
The bench pushes all 256 byte values through one frame under three backpressure patterns. A framer that leaves 0x7D, 0x7E or 0x7F unescaped, or that escapes a neighbouring value, shows up as a byte mismatch in the computed stream. Stray close and data beats outside a frame are checked for producing no output at all, which catches a framer that emits delimiters for a frame that was never opened. An open beat inside a frame must produce four delimiters, so a framer that forgets to close the old frame produces a short stream. Stall counts in the acceptance handshake are compared against the computed expansion lengths, and output bytes held under backpressure must not change; a framer that drops the second byte of an escape, or lets a new beat overwrite a pending one, breaks one of these checks.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] ESC_BYTE  = 8'h7D;
    localparam logic [7:0] ESC_FLIP  = 8'h20;

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } rx_beat_t;

    typedef enum logic [2:0] {
        K_DROP,
        K_OPEN,
        K_REOPEN,
        K_CLOSE,
        K_LIT,
        K_ESC
    } beat_kind_t;

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == 8'h7D) || (b == 8'h7E) || (b == 8'h7F);
    endfunction

    function automatic beat_kind_t classify(input rx_beat_t b, input logic open_now);
        beat_kind_t k;
        if (b.sof)
            k = open_now ? K_REOPEN : K_OPEN;
        else if (b.eof)
            k = open_now ? K_CLOSE : K_DROP;
        else if (!open_now)
            k = K_DROP;
        else if (is_reserved(b.data))
            k = K_ESC;
        else
            k = K_LIT;
        return k;
    endfunction

endpackage

// File: rtl/rxfr_burst.sv
module rxfr_burst
    import rxfr_pkg::*;
#(
    parameter int DELIM_REPS = 2,
    localparam int MAX_BURST = 2 * DELIM_REPS,
    localparam int CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  rx_beat_t                       beat,
    input  logic                           open_now,
    output logic [MAX_BURST-1:0][7:0]      bytes,
    output logic [CNT_W-1:0]               len,
    output logic                           open_next
);

    beat_kind_t kind;

    assign kind = classify(beat, open_now);

    always_comb begin
        case (kind)
            K_OPEN:   len = CNT_W'(DELIM_REPS);
            K_REOPEN: len = CNT_W'(MAX_BURST);
            K_CLOSE:  len = CNT_W'(DELIM_REPS);
            K_LIT:    len = CNT_W'(1);
            K_ESC:    len = CNT_W'(2);
            default:  len = '0;
        endcase
    end

    always_comb begin
        if (beat.sof)
            open_next = 1'b1;
        else if (beat.eof)
            open_next = 1'b0;
        else
            open_next = open_now;
    end

    for (genvar i = 0; i < MAX_BURST; i++) begin : g_slot
        always_comb begin
            case (kind)
                K_LIT:   bytes[i] = (i == 0) ? beat.data : 8'h00;
                K_ESC: begin
                    if (i == 0)
                        bytes[i] = ESC_BYTE;
                    else if (i == 1)
                        bytes[i] = beat.data ^ ESC_FLIP;
                    else
                        bytes[i] = 8'h00;
                end
                K_DROP:  bytes[i] = 8'h00;
                default: bytes[i] = FLAG_BYTE;
            endcase
        end
    end

endmodule

// File: rtl/rxfr_outq.sv
module rxfr_outq #(
    parameter int MAX_BURST = 4,
    localparam int CNT_W    = $clog2(MAX_BURST + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [MAX_BURST-1:0][7:0]  load_bytes,
    input  logic [CNT_W-1:0]           load_len,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [7:0]                 out_data,
    output logic                       can_take
);

    logic [7:0]       slot_q [MAX_BURST];
    logic [CNT_W-1:0] cnt_q;
    logic             pop;

    assign out_valid = (cnt_q != '0);
    assign out_data  = slot_q[0];
    assign pop       = out_valid && out_ready;
    assign can_take  = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && out_ready);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_len;
        else if (pop)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    for (genvar i = 0; i < MAX_BURST; i++) begin : g_q
        if (i == MAX_BURST - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[i] <= 8'h00;
                else if (load)
                    slot_q[i] <= load_bytes[i];
                else if (pop)
                    slot_q[i] <= 8'h00;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[i] <= 8'h00;
                else if (load)
                    slot_q[i] <= load_bytes[i];
                else if (pop)
                    slot_q[i] <= slot_q[i+1];
            end
        end
    end

    // R9: a stalled byte is held unchanged
    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: refusing input only happens while output is pending
    assert_stall_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        !can_take |-> out_valid);

endmodule

// File: rtl/rxfr_ovf.sv
module rxfr_ovf (
    input  logic clk,
    input  logic rst,
    input  logic overrun,
    input  logic frame_open_accepted,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (overrun)
            flag <= 1'b1;
        else if (frame_open_accepted)
            flag <= 1'b0;
    end

    // R11: an overrun pulse is always reflected on the next cycle
    assert_no_overflow_lost_R11: assert property (@(posedge clk) disable iff (rst)
        overrun |=> flag);

endmodule

// File: rtl/fir_rx_framer.sv
module fir_rx_framer
    import rxfr_pkg::*;
#(
    parameter int DELIM_REPS = 2,
    localparam int MAX_BURST = 2 * DELIM_REPS,
    localparam int CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_overrun,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       overflow
);

    rx_beat_t                  beat;
    logic                      open_q;
    logic                      open_next;
    logic                      accept;
    logic [MAX_BURST-1:0][7:0] burst_bytes;
    logic [CNT_W-1:0]          burst_len;

    assign beat   = '{sof: in_sof, eof: in_eof, data: in_data};
    assign accept = in_valid && in_ready;

    rxfr_burst #(.DELIM_REPS(DELIM_REPS)) u_burst (
        .beat      (beat),
        .open_now  (open_q),
        .bytes     (burst_bytes),
        .len       (burst_len),
        .open_next (open_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (accept)
            open_q <= open_next;
    end

    rxfr_outq #(.MAX_BURST(MAX_BURST)) u_outq (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_bytes (burst_bytes),
        .load_len   (burst_len),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .can_take   (in_ready)
    );

    rxfr_ovf u_ovf (
        .clk                 (clk),
        .rst                 (rst),
        .overrun             (in_overrun),
        .frame_open_accepted (accept && in_sof),
        .flag                (overflow)
    );

    // R4: an escape leader is immediately followed by a substituted code
    assert_escape_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == ESC_BYTE) |=>
        (out_valid && (out_data == 8'h5D || out_data == 8'h5E || out_data == 8'h5F)));

    // R6/R7: a beat outside a frame that is not an open marker yields no output
    assert_idle_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !open_q && !in_sof && !out_valid) |=> !out_valid);

endmodule

// File: tb/test_fir_rx_framer.sv
module test_fir_rx_framer;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sof, in_eof, in_overrun, out_ready;
    logic [7:0] in_data;
    logic       in_ready, out_valid, overflow;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    fir_rx_framer #(.DELIM_REPS(2)) i_fir_rx_framer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_overrun(in_overrun),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .overflow(overflow)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] exp_b [0:8191];
    string      exp_t [0:8191];
    int         wr = 0;
    int         rd = 0;
    bit         model_open = 0;
    int         stalls = 0;
    int         rdy_mode = 0;
    logic [7:0] lf = 8'h5A;
    bit         prev_stall = 0;
    logic [7:0] prev_d = 8'h00;
    bit         done = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        exp_b[wr] = b;
        exp_t[wr] = tag;
        wr++;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic send(input bit s, input bit e, input logic [7:0] d);
        if (s) begin
            if (model_open) begin
                repeat (4) push(8'h7E, "R8");
            end else begin
                repeat (2) push(8'h7E, "R2");
            end
            model_open = 1;
        end else if (e) begin
            if (model_open) begin
                repeat (2) push(8'h7E, "R5");
            end
            model_open = 0;
        end else if (model_open) begin
            if (d == 8'h7D || d == 8'h7E || d == 8'h7F) begin
                push(8'h7D, "R4");
                push(d ^ 8'h20, "R4");
            end else begin
                push(d, "R3");
            end
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = s;
        in_eof   = e;
        in_data  = d;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int guard;
        idle(1);
        guard = 0;
        while (rd != wr && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        case (rdy_mode)
            1:       out_ready <= ~out_ready;
            2:       out_ready <= lf[0] | lf[2];
            default: out_ready <= 1'b1;
        endcase
    end

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            if (prev_stall)
                check(out_valid && out_data == prev_d, "R9", {out_valid, out_data}, {1'b1, prev_d});
            if (out_valid && out_ready) begin
                if (rd < wr) begin
                    check(out_data == exp_b[rd], exp_t[rd], out_data, exp_b[rd]);
                    rd++;
                end else begin
                    check(1'b0, "R6/R7 unexpected byte", out_data, 0);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_d     = out_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; in_overrun = 1'b0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);

        // R6 / R7: beats outside a frame are consumed silently
        send(1'b0, 1'b1, 8'h00);
        send(1'b0, 1'b0, 8'h11);
        send(1'b0, 1'b0, 8'h7E);
        idle(5);
        check(out_valid == 1'b0, "R6 no output after stray close", out_valid, 0);
        check(rd == 0, "R7 no bytes after stray data", rd, 0);
        check(in_ready == 1'b1, "R6 in_ready after stray beats", in_ready, 1);

        // R10 throughput and R4 expansion stalls
        send(1'b1, 1'b0, 8'h00);
        idle(3);
        stalls = 0;
        for (int i = 0; i < 16; i++) send(1'b0, 1'b0, 8'(i * 5 + 1));
        check(stalls == 0, "R10 plain data stalls", stalls, 0);
        stalls = 0;
        send(1'b0, 1'b0, 8'h7D);
        send(1'b0, 1'b0, 8'h7E);
        send(1'b0, 1'b0, 8'h7F);
        send(1'b0, 1'b0, 8'h7D);
        send(1'b0, 1'b0, 8'h42);
        check(stalls == 4, "R10 escape stalls", stalls, 4);
        send(1'b0, 1'b1, 8'h00);
        drain();
        check(rd == wr, "R5 stream drained", rd, wr);

        // R3 / R4: every byte value under three backpressure patterns
        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            send(1'b1, 1'b0, 8'h00);
            for (int b = 0; b < 256; b++) send(1'b0, 1'b0, 8'(b));
            send(1'b0, 1'b1, 8'h00);
            drain();
            check(rd == wr, "R3 full sweep drained", rd, wr);
        end

        // R8: open inside an open frame closes the old frame first
        rdy_mode = 2;
        send(1'b1, 1'b0, 8'h00);
        send(1'b0, 1'b0, 8'h33);
        send(1'b1, 1'b0, 8'h00);
        send(1'b0, 1'b0, 8'h44);
        send(1'b1, 1'b1, 8'h00);
        send(1'b0, 1'b1, 8'h00);
        drain();
        check(rd == wr, "R8 reopen drained", rd, wr);
        rdy_mode = 0;

        // R11: sticky overrun, cleared by the next open
        @(negedge clk);
        in_overrun = 1'b1;
        @(negedge clk);
        in_overrun = 1'b0;
        #1;
        check(overflow == 1'b1, "R11 set", overflow, 1);
        idle(4);
        check(overflow == 1'b1, "R11 sticky", overflow, 1);
        send(1'b1, 1'b0, 8'h00);
        idle(1);
        #1;
        check(overflow == 1'b0, "R11 cleared on open", overflow, 0);
        send(1'b0, 1'b1, 8'h00);
        drain();
        check(rd == wr, "R11 stream drained", rd, wr);

        done = 1;
        summary();
        $finish;
    end

endmodule